// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block sits between a bus write port and a peripheral's register file and decides which writes may reach the registers. Two key registers, each at its own address, must both hold their own 32-bit magic value before any other write is passed on. When either key holds anything else, writes to the rest of the address space are silently dropped. Writes to the key registers themselves are always accepted, so software can always unlock and relock the gate.

The expected software sequence is: write the first magic value to the first key, write the second magic value to the second key, perform the protected writes, then write zero to both keys to close the gate again. The gate only stores whether each key currently matches, so reading a key returns 1 in bit 0 when that key is correct and 0 otherwise, and the magic values cannot be read back. Reads of other addresses are not handled here and are never held up by the gate.

Top module: `regwr_keygate`

## Requirements
- R1: After reset both keys read as incorrect, `gate_open` is 0 and `prot_we` is 0.
- R2: With 0x83E70B13 written at address 0x6C and 0x95A4F1E0 written at address 0x70, `gate_open` is 1 from the cycle after the second of those writes.
- R3: A write of any other value to either key (a single flipped bit, or zero) makes `gate_open` 0 from the next cycle; writing zero to both keys leaves the gate closed.
- R4: While `gate_open` is 1, a write to any address other than 0x6C and 0x70 gives `prot_we` = 1 in the next cycle with `prot_addr` and `prot_wdata` equal to the written address and data, and `prot_we` returns to 0 afterwards.
- R5: While `gate_open` is 0, a write to any address other than the two keys leaves `prot_we` at 0.
- R6: A write to either key address never raises `prot_we`, whether the gate is open or closed, and is always stored.
- R7: A read at a key address gives `key_rd_valid` = 1 in the next cycle with `key_rd_data` bit 0 equal to 1 if that key holds its magic value and all other bits 0; reads at other addresses leave `key_rd_valid` at 0.
- R8: The gate opens whether the keys are written first-then-second or second-then-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| prot_we | output | 1 | Qualified write enable to the protected registers |
| prot_addr | output | ADDR_W (8) | Address of the qualified write |
| prot_wdata | output | DATA_W (32) | Data of the qualified write |
| gate_open | output | 1 | 1 while both keys hold their magic values |
| key_rd_valid | output | 1 | Key read data valid |
| key_rd_data | output | DATA_W (32) | Key read data: bit 0 is the key-correct flag |

## Verification
On every cycle the assertions check that `prot_we` only follows a non-key write made while the gate was open, that key writes never leak through, that the gate only opens after a key write, that a wrong key value closes it, and that key read data never carries more than one flag bit. Only the bench's scenarios can show that the exact magic values open the gate in either order, that every single-bit corruption of either key keeps it shut, and that every non-key address is forwarded with its data when open and dropped when closed.

// File: rtl/keygate_pkg.sv
package keygate_pkg;
  localparam int NKEYS = 2;

  typedef struct packed {
    logic valid;
    logic flag;
  } key_rd_t;
endpackage

// File: rtl/keygate_slot.sv
module keygate_slot #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = '0,
  parameter logic [DATA_W-1:0] SLOT_MAGIC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic              ok
);
  assign hit = (addr == SLOT_ADDR);

  // Only the comparison result is kept; the key word itself is not stored.
  always_ff @(posedge clk) begin
    if (rst)
      ok <= 1'b0;
    else if (wr && hit)
      ok <= (wdata == SLOT_MAGIC);
  end
endmodule

// File: rtl/keygate_wrq.sv
module keygate_wrq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              key_hit,
  input  logic              open,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= wr && !key_hit && open;
      if (wr) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/keygate_rdport.sv
module keygate_rdport
  import keygate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [NKEYS-1:0] hit,
  input  logic [NKEYS-1:0] ok,
  output logic             rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  key_rd_t nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (rd && hit[i]) begin
        nxt.valid = 1'b1;
        nxt.flag  = ok[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= nxt.valid;
      rd_data  <= {{(DATA_W-1){1'b0}}, nxt.flag};
    end
  end
endmodule

// File: rtl/regwr_keygate.sv
module regwr_keygate
  import keygate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              prot_we,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [DATA_W-1:0] prot_wdata,
  output logic              gate_open,
  output logic              key_rd_valid,
  output logic [DATA_W-1:0] key_rd_data
);
  localparam logic [ADDR_W-1:0] SLOT_ADDRS  [NKEYS] = '{KEY0_ADDR, KEY1_ADDR};
  localparam logic [DATA_W-1:0] SLOT_MAGICS [NKEYS] = '{KEY0_MAGIC, KEY1_MAGIC};

  logic [NKEYS-1:0] slot_hit;
  logic [NKEYS-1:0] slot_ok;

  for (genvar g = 0; g < NKEYS; g++) begin : g_slot
    keygate_slot #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .SLOT_ADDR(SLOT_ADDRS[g]),
      .SLOT_MAGIC(SLOT_MAGICS[g])
    ) u_slot (
      .clk(clk),
      .rst(rst),
      .wr(bus_wr),
      .addr(bus_addr),
      .wdata(bus_wdata),
      .hit(slot_hit[g]),
      .ok(slot_ok[g])
    );
  end

  assign gate_open = &slot_ok;

  keygate_wrq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_wrq (
    .clk(clk),
    .rst(rst),
    .wr(bus_wr),
    .key_hit(|slot_hit),
    .open(gate_open),
    .addr(bus_addr),
    .wdata(bus_wdata),
    .we_q(prot_we),
    .addr_q(prot_addr),
    .wdata_q(prot_wdata)
  );

  keygate_rdport #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk(clk),
    .rst(rst),
    .rd(bus_rd),
    .hit(slot_hit),
    .ok(slot_ok),
    .rd_valid(key_rd_valid),
    .rd_data(key_rd_data)
  );
endmodule

// File: rtl/regwr_keygate_chk.sv
module regwr_keygate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              prot_we,
  input logic              gate_open,
  input logic              key_rd_valid,
  input logic [DATA_W-1:0] key_rd_data
);
  logic key_adr;
  assign key_adr = (bus_addr == KEY0_ADDR) || (bus_addr == KEY1_ADDR);

  // R4 / R5: a qualified write only follows a non-key write made while open
  a_r5_we_needs_open: assert property (@(posedge clk) disable iff (rst)
    prot_we |-> ($past(bus_wr) && $past(gate_open) && !$past(key_adr)));

  // R6: key writes never reach the protected registers
  a_r6_key_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && key_adr) |=> !prot_we);

  // R2: the gate only opens right after a key write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_open) |-> ($past(bus_wr) && $past(key_adr)));

  // R3: a wrong value in either key closes the gate
  a_r3_bad_key0_locks: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == KEY0_ADDR && bus_wdata != KEY0_MAGIC) |=> !gate_open);
  a_r3_bad_key1_locks: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == KEY1_ADDR && bus_wdata != KEY1_MAGIC) |=> !gate_open);

  // R7: key read data is a single flag bit
  a_r7_flag_only: assert property (@(posedge clk) disable iff (rst)
    key_rd_valid |-> (key_rd_data[DATA_W-1:1] == '0));
endmodule

bind regwr_keygate regwr_keygate_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .KEY0_ADDR(KEY0_ADDR),
  .KEY1_ADDR(KEY1_ADDR),
  .KEY0_MAGIC(KEY0_MAGIC),
  .KEY1_MAGIC(KEY1_MAGIC)
) u_chk (
  .clk(clk),
  .rst(rst),
  .bus_wr(bus_wr),
  .bus_addr(bus_addr),
  .bus_wdata(bus_wdata),
  .prot_we(prot_we),
  .gate_open(gate_open),
  .key_rd_valid(key_rd_valid),
  .key_rd_data(key_rd_data)
);

// File: tb/regwr_keygate_tb.sv
`timescale 1ns/1ps
module regwr_keygate_tb;
  localparam logic [7:0]  K0A = 8'h6C;
  localparam logic [7:0]  K1A = 8'h70;
  localparam logic [31:0] K0M = 32'h83E7_0B13;
  localparam logic [31:0] K1M = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        prot_we;
  logic [7:0]  prot_addr;
  logic [31:0] prot_wdata;
  logic        gate_open;
  logic        key_rd_valid;
  logic [31:0] key_rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regwr_keygate u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .prot_we(prot_we), .prot_addr(prot_addr), .prot_wdata(prot_wdata),
    .gate_open(gate_open), .key_rd_valid(key_rd_valid), .key_rd_data(key_rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge; results of the captured access are visible on return.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    chk("R1 gate_open", gate_open, 0);
    chk("R1 prot_we", prot_we, 0);
    rd(K0A);
    chk("R1 key0 flag", {key_rd_valid, key_rd_data}, {1'b1, 32'h0});
    rd(K1A);
    chk("R1 key1 flag", {key_rd_valid, key_rd_data}, {1'b1, 32'h0});

    // R5 locked sweep over every non-key address
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != K0A && a[7:0] != K1A) begin
        wr(a[7:0], 32'hA5A5_0000 ^ a);
        chk("R5 locked drop", prot_we, 0);
      end
    end

    // R2 unlock in documented order, checking partial state
    wr(K0A, K0M);
    chk("R2 half open", gate_open, 0);
    chk("R6 key0 no we", prot_we, 0);
    rd(K0A);
    chk("R7 key0 ok", {key_rd_valid, key_rd_data}, {1'b1, 32'h1});
    wr(K1A, K1M);
    chk("R2 open", gate_open, 1);
    chk("R6 key1 no we", prot_we, 0);
    rd(K1A);
    chk("R7 key1 ok", {key_rd_valid, key_rd_data}, {1'b1, 32'h1});
    rd(8'h00);
    chk("R7 non-key read", key_rd_valid, 0);

    // R4 open sweep
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != K0A && a[7:0] != K1A) begin
        logic [31:0] d;
        d = (a * 32'h0101_0107) ^ 32'h5A5A_C3C3;
        wr(a[7:0], d);
        chk("R4 forward we", prot_we, 1);
        chk("R4 forward addr", prot_addr, a[7:0]);
        chk("R4 forward data", prot_wdata, d);
        idle();
        chk("R4 we single cycle", prot_we, 0);
      end
    end

    // R6 rewriting a key while open: no leak, gate stays open
    wr(K1A, K1M);
    chk("R6 key rewrite no we", prot_we, 0);
    chk("R6 key rewrite open", gate_open, 1);

    // R3 each single-bit corruption of each key closes the gate
    for (int b = 0; b < 32; b++) begin
      wr(K0A, K0M ^ (32'h1 << b));
      chk("R3 key0 bitflip closes", gate_open, 0);
      wr(K0A, K0M);
      chk("R3 key0 restore", gate_open, 1);
      wr(K1A, K1M ^ (32'h1 << b));
      chk("R3 key1 bitflip closes", gate_open, 0);
      wr(8'h10, 32'h1234);
      chk("R5 drop after bitflip", prot_we, 0);
      wr(K1A, K1M);
      chk("R3 key1 restore", gate_open, 1);
    end

    // Swapped magics do not open
    wr(K0A, K1M);
    wr(K1A, K0M);
    chk("R3 swapped magics", gate_open, 0);

    // R8 reverse order
    wr(K1A, K1M);
    chk("R8 half open reverse", gate_open, 0);
    wr(K0A, K0M);
    chk("R8 open reverse", gate_open, 1);
    wr(8'h20, 32'hCAFE_F00D);
    chk("R8 forward after reverse", {prot_we, prot_addr, prot_wdata}, {1'b1, 8'h20, 32'hCAFE_F00D});

    // R3 relock by zeros
    wr(K0A, 32'h0);
    chk("R3 zero key0 locks", gate_open, 0);
    wr(K1A, 32'h0);
    chk("R3 zero both locked", gate_open, 0);
    rd(K0A);
    chk("R3 key0 reads 0", {key_rd_valid, key_rd_data}, {1'b1, 32'h0});
    rd(K1A);
    chk("R3 key1 reads 0", {key_rd_valid, key_rd_data}, {1'b1, 32'h0});
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R5 drop after relock", prot_we, 0);

    // R1 reset from open state
    wr(K0A, K0M);
    wr(K1A, K1M);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset closes", gate_open, 0);
    wr(8'h08, 32'h1);
    chk("R1 drop after reset", prot_we, 0);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule